// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address to a physical page frame after a translation-cache miss. It takes one request at a time. A request carries the linear address, a user/supervisor flag, a write flag, a generation mode and the page-directory base. The walker fetches the directory entry over a single request/ready memory port. For a 4 KB page it then fetches the table entry as well. It writes an entry back whenever its accessed or dirty flag has to be set.

The walk ends in one of two ways. It can return a 20-bit physical frame together with a 4-bit permission code for the cache to store. It can instead report a page fault, marked as either not-present or protection.

Large 4 MB pages are recognised by the page-size flag in the directory entry. Such a page is finished from that entry alone. The mode input selects among three generations of behaviour. They differ in how the user/supervisor flags of the two levels are merged, and in when the directory entry's accessed flag gets set.

Top module: `page_walker`

## Requirements
- R1: The directory entry is read at `{dir_base[31:12],12'h000} | (lin[31:22] << 2)`. For a 4 KB page, the table entry is read at `{pde[31:12],12'h000} | (lin[21:12] << 2)`. Entry flag positions: present bit 0, writable bit 1, user bit 2, accessed bit 5, dirty bit 6, page-size bit 7.
- R2: When the directory entry has the page-size bit set, no table entry is read. The frame is `{pde[31:22], lin[21:12]}`, and the permission comes from the directory entry's user and writable bits alone.
- R3: An entry whose present bit is clear ends the walk with `fault=1` and `fault_prot=0`. That walk performs no write-back.
- R4: A user access needs the merged user bit. A user write also needs the merged writable bit. A supervisor access always passes. A failed check ends the walk with `fault=1` and `fault_prot=1`, and only the early accessed update of R6 may have been written by then.
- R5: After the check passes, the final entry is written back only if its accessed bit is clear, or if the access is a write and its dirty bit is clear. The value written sets accessed, and also sets dirty on a write.
- R6: `req_mode` selects the generation: 0 = oldest, 1 = older, 2 or 3 = newer. For a 4 KB page in modes 0 and 1, a directory entry with accessed clear gets accessed set before the table read. In the newer mode it gets accessed set only after the check passes.
- R7: In mode 0 the merged user bit is the OR of both levels' user bits. In the other modes it is the AND. The merged writable bit is always the AND.
- R8: The permission code is: bit0 supervisor read, bit1 user read, bit2 supervisor write, bit3 user write. A user page gives 4'b0011, or 4'b1111 when the access is a write to a writable page. A supervisor page gives 4'b0001, or 4'b0101 when the access is a write.
- R9: `req_ready` is high only when idle, and a request raised while the walker is busy is ignored. `done` is a one-cycle pulse. `fault`, `fault_prot`, `frame` and `acc` hold their values until the next request is accepted.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable. An access completes in the cycle where both are high, and read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin | input | 32 | Linear address to translate |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| req_write | input | 1 | 1 = write access |
| req_mode | input | 2 | Generation mode (R6) |
| dir_base | input | 32 | Page-directory base, bits 11:0 ignored |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read |
| mem_ready | input | 1 | Memory completes the access |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Walk ended in a page fault |
| fault_prot | output | 1 | Fault cause: 1 protection, 0 not present |
| frame | output | 20 | Physical page frame |
| acc | output | 4 | Permission code (R8) |

## Verification
The assertions rely on a memory that never raises `mem_ready` unless a request is pending. They also assume the request inputs are sampled only in the idle cycle that accepts them. The bench's memory model answers only while `mem_req` is high, holding each request for zero or one wait cycle. It changes request inputs only at falling edges. One directed test keeps `req_valid` high during a whole walk, so the idle-only acceptance check sees a real conflicting request.

// File: rtl/walk_pkg.sv
package walk_pkg;

    // entry flag positions
    localparam int ENT_P  = 0;
    localparam int ENT_RW = 1;
    localparam int ENT_US = 2;
    localparam int ENT_A  = 5;
    localparam int ENT_D  = 6;
    localparam int ENT_PS = 7;

    // generation modes
    typedef enum logic [1:0] {
        GEN_OLDEST = 2'd0,
        GEN_OLDER  = 2'd1,
        GEN_NEWER  = 2'd2,
        GEN_NEWER2 = 2'd3
    } gen_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_EVAL_DIR,
        ST_WB_DIR_EARLY,
        ST_RD_TBL,
        ST_EVAL_TBL,
        ST_WB_DIR_LATE,
        ST_WB_TBL,
        ST_WB_BIG,
        ST_FINISH
    } walk_state_e;

    typedef struct packed {
        logic        fault;
        logic        prot;
        logic [19:0] frame;
        logic [3:0]  acc;
    } walk_result_t;

    function automatic logic late_dir_access(input gen_e g);
        return (g == GEN_NEWER) || (g == GEN_NEWER2);
    endfunction

endpackage

// File: rtl/walk_addr.sv
module walk_addr
    import walk_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int DIR_BITS  = 10
) (
    input  logic [VA_W-1:0]           base,
    input  logic [VA_W-1:0]           lin,
    input  logic [VA_W-1:0]           pde,
    output logic [VA_W-1:0]           dir_addr,
    output logic [VA_W-1:0]           tbl_addr,
    output logic [VA_W-PAGE_BITS-1:0] big_frame
);
    localparam int TBL_BITS = VA_W - PAGE_BITS - DIR_BITS;
    localparam int FRAME_W  = VA_W - PAGE_BITS;

    logic [VA_W-1:0] dir_off;
    logic [VA_W-1:0] tbl_off;

    always_comb begin
        dir_off   = VA_W'(lin[VA_W-1 -: DIR_BITS]) << 2;
        tbl_off   = VA_W'(lin[PAGE_BITS +: TBL_BITS]) << 2;
        dir_addr  = {base[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}} | dir_off;
        tbl_addr  = {pde[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}} | tbl_off;
        big_frame = FRAME_W'({pde[VA_W-1 -: DIR_BITS], lin[PAGE_BITS +: TBL_BITS]});
    end
endmodule

// File: rtl/walk_perm.sv
module walk_perm
    import walk_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] pde,
    input  logic [ENT_W-1:0] pte,
    input  logic             big,
    input  gen_e             gen,
    input  logic             user,
    input  logic             write,
    output logic             allow,
    output logic [3:0]       acc
);
    logic us;
    logic rw;

    always_comb begin
        if (big) begin
            us = pde[ENT_US];
            rw = pde[ENT_RW];
        end else begin
            us = (gen == GEN_OLDEST) ? (pde[ENT_US] | pte[ENT_US])
                                     : (pde[ENT_US] & pte[ENT_US]);
            rw = pde[ENT_RW] & pte[ENT_RW];
        end
        allow = !user || (us && (!write || rw));
        if (us)
            acc = (write && rw) ? 4'b1111 : 4'b0011;
        else
            acc = write ? 4'b0101 : 4'b0001;
    end
endmodule

// File: rtl/walk_update.sv
module walk_update
    import walk_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             write,
    output logic             need,
    output logic [ENT_W-1:0] new_val
);
    always_comb begin
        need    = !entry[ENT_A] || (write && !entry[ENT_D]);
        new_val = entry;
        new_val[ENT_A] = 1'b1;
        if (write)
            new_val[ENT_D] = 1'b1;
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import walk_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int DIR_BITS  = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_lin,
    input  logic                      req_user,
    input  logic                      req_write,
    input  logic [1:0]                req_mode,
    input  logic [VA_W-1:0]           dir_base,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [VA_W-1:0]           mem_addr,
    output logic [VA_W-1:0]           mem_wdata,
    input  logic [VA_W-1:0]           mem_rdata,
    input  logic                      mem_ready,
    output logic                      done,
    output logic                      fault,
    output logic                      fault_prot,
    output logic [VA_W-PAGE_BITS-1:0] frame,
    output logic [3:0]                acc
);
    localparam int FRAME_W = VA_W - PAGE_BITS;

    walk_state_e     state;
    logic [VA_W-1:0] lin_q, base_q, pde_q, pte_q;
    logic            user_q, wr_q;
    gen_e            gen_q;
    walk_result_t    res;

    logic [VA_W-1:0]    dir_addr, tbl_addr;
    logic [FRAME_W-1:0] big_frame;
    logic               allow;
    logic [3:0]         acc_w;
    logic               pte_need, big_need, dir_need;
    logic [VA_W-1:0]    pte_new, big_new, dir_new;

    walk_addr #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .DIR_BITS(DIR_BITS)) u_addr (
        .base(base_q), .lin(lin_q), .pde(pde_q),
        .dir_addr(dir_addr), .tbl_addr(tbl_addr), .big_frame(big_frame)
    );

    walk_perm #(.ENT_W(VA_W)) u_perm (
        .pde(pde_q), .pte(pte_q), .big(pde_q[ENT_PS]), .gen(gen_q),
        .user(user_q), .write(wr_q), .allow(allow), .acc(acc_w)
    );

    walk_update #(.ENT_W(VA_W)) u_upd_tbl (
        .entry(pte_q), .write(wr_q), .need(pte_need), .new_val(pte_new)
    );
    walk_update #(.ENT_W(VA_W)) u_upd_big (
        .entry(pde_q), .write(wr_q), .need(big_need), .new_val(big_new)
    );
    walk_update #(.ENT_W(VA_W)) u_upd_dir (
        .entry(pde_q), .write(1'b0), .need(dir_need), .new_val(dir_new)
    );

    // memory port driven from state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            ST_WB_DIR_EARLY, ST_WB_DIR_LATE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_new;
            end
            ST_WB_BIG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = big_new;
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            ST_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = pte_new;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            lin_q  <= '0;
            base_q <= '0;
            pde_q  <= '0;
            pte_q  <= '0;
            user_q <= 1'b0;
            wr_q   <= 1'b0;
            gen_q  <= GEN_OLDEST;
            res    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    lin_q  <= req_lin;
                    base_q <= dir_base;
                    user_q <= req_user;
                    wr_q   <= req_write;
                    gen_q  <= gen_e'(req_mode);
                    res    <= '0;
                    state  <= ST_RD_DIR;
                end
                ST_RD_DIR: if (mem_ready) begin
                    pde_q <= mem_rdata;
                    state <= ST_EVAL_DIR;
                end
                ST_EVAL_DIR: begin
                    if (!pde_q[ENT_P]) begin
                        res.fault <= 1'b1;
                        state     <= ST_FINISH;
                    end else if (pde_q[ENT_PS]) begin
                        if (!allow) begin
                            res.fault <= 1'b1;
                            res.prot  <= 1'b1;
                            state     <= ST_FINISH;
                        end else begin
                            res.frame <= big_frame;
                            res.acc   <= acc_w;
                            state     <= big_need ? ST_WB_BIG : ST_FINISH;
                        end
                    end else if (!late_dir_access(gen_q) && dir_need) begin
                        state <= ST_WB_DIR_EARLY;
                    end else begin
                        state <= ST_RD_TBL;
                    end
                end
                ST_WB_DIR_EARLY: if (mem_ready) begin
                    pde_q <= dir_new;
                    state <= ST_RD_TBL;
                end
                ST_RD_TBL: if (mem_ready) begin
                    pte_q <= mem_rdata;
                    state <= ST_EVAL_TBL;
                end
                ST_EVAL_TBL: begin
                    if (!pte_q[ENT_P]) begin
                        res.fault <= 1'b1;
                        state     <= ST_FINISH;
                    end else if (!allow) begin
                        res.fault <= 1'b1;
                        res.prot  <= 1'b1;
                        state     <= ST_FINISH;
                    end else begin
                        res.frame <= pte_q[VA_W-1:PAGE_BITS];
                        res.acc   <= acc_w;
                        if (dir_need)
                            state <= ST_WB_DIR_LATE;
                        else
                            state <= pte_need ? ST_WB_TBL : ST_FINISH;
                    end
                end
                ST_WB_DIR_LATE: if (mem_ready) begin
                    pde_q <= dir_new;
                    state <= pte_need ? ST_WB_TBL : ST_FINISH;
                end
                ST_WB_TBL, ST_WB_BIG: if (mem_ready) begin
                    state <= ST_FINISH;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign done       = (state == ST_FINISH);
    assign fault      = res.fault;
    assign fault_prot = res.prot;
    assign frame      = res.frame;
    assign acc        = res.acc;

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req && !done));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && $past(req_ready) && !$past(req_valid)) |->
            ($stable(fault) && $stable(fault_prot) && $stable(frame) && $stable(acc)));

    // R5
    wb_sets_accessed_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[ENT_A]);

    // R8
    acc_code_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (acc[0] && (!acc[3] || acc[1])));
endmodule

// File: tb/page_walker_test.sv
module page_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'd2;
    logic [31:0] dir_base = 32'h0001_0000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        done, fault, fault_prot;
    logic [19:0] frame;
    logic [3:0]  acc;

    int errors = 0;
    int checks = 0;
    int rd_count = 0;
    int wr_count = 0;
    int lat = 0;
    int waitc = 0;
    logic [31:0] rd_log [2];
    logic [31:0] mem [logic [31:0]];

    localparam logic [31:0] LIN_A    = 32'h0040_3123;
    localparam logic [31:0] PDE_ADDR = 32'h0001_0004;
    localparam logic [31:0] PTE_ADDR = 32'h0002_000C;

    always #4 clk = ~clk;

    page_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_user(req_user), .req_write(req_write),
        .req_mode(req_mode), .dir_base(dir_base), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
        .fault(fault), .fault_prot(fault_prot), .frame(frame), .acc(acc)
    );

    // memory model: answers at falling edges after lat wait cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_req) begin
            if (waitc < lat) begin
                waitc <= waitc + 1;
            end else begin
                waitc     <= 0;
                mem_ready <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_count <= wr_count + 1;
                end else begin
                    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    if (rd_count < 2) rd_log[rd_count] <= mem_addr;
                    rd_count <= rd_count + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 200);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 walk timeout actual=0 expected=1");
        end
    endtask

    task automatic walk(input logic [1:0] md, input logic usr, input logic wr, input logic [31:0] lin);
        @(negedge clk);
        rd_count = 0;
        wr_count = 0;
        req_mode  = md;
        req_user  = usr;
        req_write = wr;
        req_lin   = lin;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    typedef struct packed {
        logic [3:0]  tag;
        logic [1:0]  mode;
        logic        usr;
        logic        wr;
        logic [31:0] pde;
        logic [31:0] pte;
        logic        flt;
        logic        prot;
        logic [19:0] frm;
        logic [3:0]  ac;
        logic [31:0] pde_a;
        logic [31:0] pte_a;
    } vec_t;

    localparam vec_t VT [16] = '{
        // R5 R6 R8: newer mode user read, both flags set late
        '{4'd5, 2'd2, 1'b1, 1'b0, 32'h00020007, 32'h55000007, 1'b0, 1'b0, 20'h55000, 4'h3, 32'h00020027, 32'h55000027},
        // R5 R8: user write marks dirty
        '{4'd5, 2'd2, 1'b1, 1'b1, 32'h00020027, 32'h55000027, 1'b0, 1'b0, 20'h55000, 4'hF, 32'h00020027, 32'h55000067},
        // R4 R6: protection fault, newer mode writes nothing
        '{4'd4, 2'd2, 1'b1, 1'b1, 32'h00020007, 32'h55000025, 1'b1, 1'b1, 20'h0, 4'h0, 32'h00020007, 32'h55000025},
        // R6: older mode sets directory accessed before the fault
        '{4'd6, 2'd1, 1'b1, 1'b1, 32'h00020007, 32'h55000025, 1'b1, 1'b1, 20'h0, 4'h0, 32'h00020027, 32'h55000025},
        // R3: directory not present
        '{4'd3, 2'd2, 1'b0, 1'b0, 32'h00020006, 32'h55000067, 1'b1, 1'b0, 20'h0, 4'h0, 32'h00020006, 32'h55000067},
        // R3: table not present
        '{4'd3, 2'd2, 1'b0, 1'b1, 32'h00020027, 32'h55000066, 1'b1, 1'b0, 20'h0, 4'h0, 32'h00020027, 32'h55000066},
        // R4 R8: supervisor write to read-only supervisor page
        '{4'd8, 2'd2, 1'b0, 1'b1, 32'h00020023, 32'h66000021, 1'b0, 1'b0, 20'h66000, 4'h5, 32'h00020023, 32'h66000061},
        // R8: supervisor read, no write-back
        '{4'd8, 2'd2, 1'b0, 1'b0, 32'h00020023, 32'h66000061, 1'b0, 1'b0, 20'h66000, 4'h1, 32'h00020023, 32'h66000061},
        // R2: 4 MB user write
        '{4'd2, 2'd2, 1'b1, 1'b1, 32'h8C000087, 32'h00000000, 1'b0, 1'b0, 20'h8C003, 4'hF, 32'h8C0000E7, 32'h00000000},
        // R2 R4: 4 MB supervisor page, user read
        '{4'd2, 2'd2, 1'b1, 1'b0, 32'h8C0000A3, 32'h00000000, 1'b1, 1'b1, 20'h0, 4'h0, 32'h8C0000A3, 32'h00000000},
        // R7: oldest mode ORs user bits
        '{4'd7, 2'd0, 1'b1, 1'b0, 32'h00020023, 32'h55000025, 1'b0, 1'b0, 20'h55000, 4'h3, 32'h00020023, 32'h55000025},
        // R7: newer mode ANDs user bits
        '{4'd7, 2'd2, 1'b1, 1'b0, 32'h00020023, 32'h55000025, 1'b1, 1'b1, 20'h0, 4'h0, 32'h00020023, 32'h55000025},
        // R6 R7: oldest mode, early accessed then protection fault
        '{4'd6, 2'd0, 1'b1, 1'b0, 32'h00020003, 32'h55000001, 1'b1, 1'b1, 20'h0, 4'h0, 32'h00020023, 32'h55000001},
        // R6: older mode success
        '{4'd6, 2'd1, 1'b1, 1'b0, 32'h00020007, 32'h55000007, 1'b0, 1'b0, 20'h55000, 4'h3, 32'h00020027, 32'h55000027},
        // R4: directory read-only blocks user write
        '{4'd4, 2'd2, 1'b1, 1'b1, 32'h00020025, 32'h55000027, 1'b1, 1'b1, 20'h0, 4'h0, 32'h00020025, 32'h55000027},
        // R2 R5: 4 MB, flags already set, no write-back
        '{4'd2, 2'd2, 1'b1, 1'b0, 32'h8C0000A7, 32'h00000000, 1'b0, 1'b0, 20'h8C003, 4'h3, 32'h8C0000A7, 32'h00000000}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset req_ready", 32'(req_ready), 32'd1);
        chk("R9 reset done", 32'(done), 32'd0);
        chk("R10 reset mem_req", 32'(mem_req), 32'd0);
        rst = 1'b0;

        foreach (VT[i]) begin
            string t;
            t = $sformatf("R%0d vec%0d", VT[i].tag, i);
            mem.delete();
            mem[PDE_ADDR] = VT[i].pde;
            mem[PTE_ADDR] = VT[i].pte;
            lat = i % 2;
            walk(VT[i].mode, VT[i].usr, VT[i].wr, LIN_A);
            chk({t, " fault"}, 32'(fault), 32'(VT[i].flt));
            if (VT[i].flt)
                chk({t, " cause"}, 32'(fault_prot), 32'(VT[i].prot));
            else begin
                chk({t, " frame"}, 32'(frame), 32'(VT[i].frm));
                chk({t, " acc"}, 32'(acc), 32'(VT[i].ac));
            end
            chk({t, " pde mem"}, mem[PDE_ADDR], VT[i].pde_a);
            chk({t, " pte mem"}, mem[PTE_ADDR], VT[i].pte_a);
            if (i == 0) begin
                // R1 entry addresses
                chk("R1 dir addr", rd_log[0], PDE_ADDR);
                chk("R1 tbl addr", rd_log[1], PTE_ADDR);
            end
            if (i == 4)
                chk("R3 no write-back", 32'(wr_count), 32'd0);
        end

        // R9: done is a pulse and results hold while idle
        mem.delete();
        mem[PDE_ADDR] = 32'h00020027;
        mem[PTE_ADDR] = 32'h77000027;
        lat = 0;
        walk(2'd2, 1'b1, 1'b0, LIN_A);
        @(negedge clk);
        chk("R9 done pulse", 32'(done), 32'd0);
        repeat (5) @(negedge clk);
        chk("R9 frame held", 32'(frame), 32'h77000);
        chk("R9 acc held", 32'(acc), 32'h3);
        chk("R9 ready idle", 32'(req_ready), 32'd1);

        // R9: request held during a busy walk is ignored
        @(negedge clk);
        rd_count  = 0;
        req_mode  = 2'd2;
        req_user  = 1'b0;
        req_write = 1'b0;
        req_lin   = LIN_A;
        req_valid = 1'b1;
        @(negedge clk);
        req_lin = 32'h0080_0000;
        wait_done();
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 busy ignore fault", 32'(fault), 32'd0);
        chk("R9 busy ignore frame", 32'(frame), 32'h77000);
        chk("R9 busy ignore reads", 32'(rd_count), 32'd2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule